// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

A serial peripheral interface host for attaching SPI devices to a simple on-chip register port. Software writes a control word that fixes clock idle level, sampling phase, bit order, word length and serial clock rate. It then writes a transmit word into the data register. The block drives chip select low, clocks the word out on MOSI and gathers the word arriving on MISO. When the word ends, it places the received word in a one-word receive buffer.

Four registers sit at word addresses 0 (control), 1 (interrupt mask), 2 (status) and 3 (data). Writes and reads use separate address buses and single-cycle strobes. Read data is registered and appears in the cycle after the strobe. A level interrupt is the OR of the status flags that the mask enables. A second word written while one is being sent waits in the transmit buffer. It follows either with chip select held low or with chip select pulsed high between the two words.

Top module: `spi_host_regport`

## Requirements
- R1: After the active-low reset is released, status reads 0x2 (transmit buffer empty only) and control reads 0. Chip select is high, the serial clock is low and the interrupt is low.
- R2: The control register keeps bits 0 to 7, a 2-bit size field at bits 11:10 and a 3-bit divider field at bits 22:20. Every other bit reads 0. Read data appears one cycle after the read strobe.
- R3: A write to the data register loads the transmit buffer and clears the tx-empty flag. The word is sent only while control bit 0 (enable) and bit 1 (master) are both 1. A word written while either bit is 0 is held, and its transfer starts once both are set. Tx-empty sets again when the word is taken.
- R4: A word is 8*(size+1) bits long and takes the low bits of the transmit buffer. Control bit 7 selects bit order: 1 sends and receives least-significant bit first, 0 sends the most-significant bit first. The received word sits in the low bits of the data register, with upper bits 0.
- R5: Control bit 4 gives the serial clock level while chip select is high. Control bit 5 selects the edge on which MISO is sampled: 0 samples on the leading edge and 1 samples on the trailing edge. The serial clock period is 2^(div+1) system clock cycles.
- R6: With control bit 2 (transmit enable) at 0, MOSI stays 0 for the whole word. With control bit 3 (receive enable) at 0, a finished word leaves the receive buffer and the rx-full flag unchanged.
- R7: Status bit 0 is rx-full, bit 1 is tx-empty, bit 2 is busy and bit 3 is lost-receive. Reading address 3 returns the receive buffer and clears rx-full.
- R8: A word that finishes while rx-full is set sets the lost-receive flag and overwrites the receive buffer with the newest word. The flag stays set until a write to address 1 with bit 3 equal to 1. That write also stores the mask.
- R9: The interrupt is high exactly while some status bit among 0, 1 and 3 is set and the mask bit at the same position is 1.
- R10: When a second word is waiting as the first ends, control bit 6 at 1 drives chip select high between the two words. At 0, chip select stays low across both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wr_addr_i | input | 2 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle |
| rd_addr_i | input | 2 | Read word address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to device |
| miso_i | input | 1 | Serial data from device |

## Verification
The bench builds the block with its default 32-bit data width, so all four word sizes are reachable, up to a full 32-bit word. The bench sweeps divider values 0 to 2, which keeps each word short while still showing the period doubling per step. Randomised words cover all four clock polarity and phase pairs and both bit orders. Directed sequences reach the held-word start, overrun, the mask write that clears the lost flag, and back-to-back words in both chip-select modes.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int REG_W  = 32;
    localparam int SIZE_W = 2;
    localparam int DIV_W  = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam int C_EN    = 0;
    localparam int C_MST   = 1;
    localparam int C_TXEN  = 2;
    localparam int C_RXEN  = 3;
    localparam int C_CPOL  = 4;
    localparam int C_CPHA  = 5;
    localparam int C_PULSE = 6;
    localparam int C_LSB   = 7;
    localparam int C_SIZE  = 10;
    localparam int C_DIV   = 20;

    localparam logic [REG_W-1:0] CTRL_KEEP =
        REG_W'(32'h0000_00FF) |
        (REG_W'((1 << SIZE_W) - 1) << C_SIZE) |
        (REG_W'((1 << DIV_W) - 1) << C_DIV);

    localparam logic [3:0] MASK_KEEP = 4'b1011;

    typedef enum logic [1:0] {
        E_IDLE = 2'd0,
        E_XFER = 2'd1,
        E_HOLD = 2'd2,
        E_GAP  = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic              cpha;
        logic              lsb;
        logic              txen;
        logic              pulse;
        logic [SIZE_W-1:0] size;
        logic [DIV_W-1:0]  div;
    } frame_cfg_t;
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              take_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              busy_i,
    output logic              go_o,
    output logic [DATA_W-1:0] word_o,
    output frame_cfg_t        cfg_o,
    output logic              cpol_o,
    output logic              rx_en_o,
    output logic              rx_full_o,
    output logic              lost_o,
    output logic [3:0]        mask_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [REG_W-1:0]  ctrl;
        logic [3:0]        mask;
        logic [DATA_W-1:0] txbuf;
        logic              txe;
        logic [DATA_W-1:0] rxbuf;
        logic              rxf;
        logic              lost;
        logic [REG_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic [3:0] stat;
    logic       rd_data_hit;

    assign stat        = {r_q.lost, busy_i, r_q.txe, r_q.rxf};
    assign rd_data_hit = rd_en_i && (rd_addr_i == A_DATA);

    always_comb begin
        r_d = r_q;
        if (take_i) r_d.txe = 1'b1;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: r_d.ctrl = wr_data_i & CTRL_KEEP;
                A_MASK: begin
                    r_d.mask = wr_data_i[3:0] & MASK_KEEP;
                    if (wr_data_i[3]) r_d.lost = 1'b0;
                end
                A_DATA: begin
                    r_d.txbuf = wr_data_i[DATA_W-1:0];
                    r_d.txe   = 1'b0;
                end
                default: ;
            endcase
        end
        if (rd_data_hit) r_d.rxf = 1'b0;
        if (done_i && r_q.ctrl[C_RXEN]) begin
            if (r_q.rxf && !rd_data_hit) r_d.lost = 1'b1;
            r_d.rxbuf = rx_word_i;
            r_d.rxf   = 1'b1;
        end
        if (rd_en_i) begin
            case (rd_addr_i)
                A_CTRL:  r_d.rdata = r_q.ctrl;
                A_MASK:  r_d.rdata = REG_W'(r_q.mask);
                A_STAT:  r_d.rdata = REG_W'(stat);
                default: r_d.rdata = REG_W'(r_q.rxbuf);
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.txe <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data_o  = r_q.rdata;
    assign go_o       = r_q.ctrl[C_EN] && r_q.ctrl[C_MST] && !r_q.txe;
    assign word_o     = r_q.txbuf;
    assign cpol_o     = r_q.ctrl[C_CPOL];
    assign rx_en_o    = r_q.ctrl[C_RXEN];
    assign rx_full_o  = r_q.rxf;
    assign lost_o     = r_q.lost;
    assign mask_o     = r_q.mask;
    assign irq_o      = |(stat & r_q.mask & MASK_KEEP);

    assign cfg_o.cpha  = r_q.ctrl[C_CPHA];
    assign cfg_o.lsb   = r_q.ctrl[C_LSB];
    assign cfg_o.txen  = r_q.ctrl[C_TXEN];
    assign cfg_o.pulse = r_q.ctrl[C_PULSE];
    assign cfg_o.size  = r_q.ctrl[C_SIZE +: SIZE_W];
    assign cfg_o.div   = r_q.ctrl[C_DIV +: DIV_W];
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic [DATA_W-1:0] word_i,
    input  frame_cfg_t        cfg_i,
    input  logic              cpol_i,
    input  logic              miso_i,
    output logic              take_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              busy_o,
    output logic              cs_no,
    output logic              sclk_o,
    output logic              mosi_o
);
    localparam int EDGE_W = $clog2(2 * DATA_W) + 1;
    localparam int HALF_W = 1 << DIV_W;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef struct packed {
        eng_state_t        st;
        frame_cfg_t        cfg;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [HALF_W-1:0] hcnt;
        logic [EDGE_W-1:0] ecnt;
        logic              tog;
    } eng_t;

    eng_t e_d, e_q;

    function automatic logic [HALF_W-1:0] half_cnt(input logic [DIV_W-1:0] dv);
        half_cnt = (HALF_W'(1) << dv) - HALF_W'(1);
    endfunction

    function automatic logic [EDGE_W-1:0] word_bits(input logic [SIZE_W-1:0] sz);
        word_bits = (EDGE_W'(sz) << 3) + EDGE_W'(8);
    endfunction

    function automatic logic [BIT_W-1:0] bit_pos(input logic lsb,
                                                 input logic [EDGE_W-1:0] nb,
                                                 input logic [EDGE_W-1:0] k);
        bit_pos = lsb ? BIT_W'(k) : BIT_W'(nb - EDGE_W'(1) - k);
    endfunction

    logic [EDGE_W-1:0] nbits;
    logic [EDGE_W-1:0] tx_k;
    logic              active;
    logic              do_load;

    assign nbits  = word_bits(e_q.cfg.size);
    assign active = (e_q.st == E_XFER) || (e_q.st == E_HOLD);

    always_comb begin
        if (e_q.cfg.cpha) tx_k = (e_q.ecnt == '0) ? '0 : ((e_q.ecnt - EDGE_W'(1)) >> 1);
        else              tx_k = e_q.ecnt >> 1;
        if (tx_k >= nbits) tx_k = nbits - EDGE_W'(1);
    end

    always_comb begin
        e_d     = e_q;
        take_o  = 1'b0;
        done_o  = 1'b0;
        do_load = 1'b0;
        case (e_q.st)
            E_IDLE: if (go_i) do_load = 1'b1;
            E_XFER: begin
                if (e_q.hcnt == '0) begin
                    e_d.tog  = ~e_q.tog;
                    e_d.hcnt = half_cnt(e_q.cfg.div);
                    if (e_q.ecnt[0] == e_q.cfg.cpha)
                        e_d.rx[bit_pos(e_q.cfg.lsb, nbits, e_q.ecnt >> 1)] = miso_i;
                    if (e_q.ecnt == (nbits << 1) - EDGE_W'(1)) e_d.st = E_HOLD;
                    e_d.ecnt = e_q.ecnt + EDGE_W'(1);
                end else begin
                    e_d.hcnt = e_q.hcnt - HALF_W'(1);
                end
            end
            E_HOLD: begin
                if (e_q.hcnt == '0) begin
                    done_o = 1'b1;
                    if (go_i && !e_q.cfg.pulse) begin
                        do_load = 1'b1;
                    end else begin
                        e_d.st   = E_GAP;
                        e_d.hcnt = half_cnt(e_q.cfg.div);
                    end
                end else begin
                    e_d.hcnt = e_q.hcnt - HALF_W'(1);
                end
            end
            default: begin
                if (e_q.hcnt == '0) e_d.st = E_IDLE;
                else                e_d.hcnt = e_q.hcnt - HALF_W'(1);
            end
        endcase
        if (do_load) begin
            take_o   = 1'b1;
            e_d.st   = E_XFER;
            e_d.cfg  = cfg_i;
            e_d.tx   = word_i;
            e_d.rx   = '0;
            e_d.ecnt = '0;
            e_d.tog  = 1'b0;
            e_d.hcnt = half_cnt(cfg_i.div);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) e_q <= '0;
        else         e_q <= e_d;
    end

    assign rx_word_o = e_q.rx;
    assign busy_o    = (e_q.st != E_IDLE);
    assign cs_no     = !active;
    assign sclk_o    = cpol_i ^ e_q.tog;
    assign mosi_o    = active && e_q.cfg.txen && e_q.tx[bit_pos(e_q.cfg.lsb, nbits, tx_k)];
endmodule

// File: rtl/spi_host_regport.sv
module spi_host_regport
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o,
    output logic             cs_no,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    logic              go, take, done, busy, cpol, rx_en, rx_full, lost;
    logic [3:0]        mask;
    logic [DATA_W-1:0] tx_word, rx_word;
    frame_cfg_t        cfg;

    spi_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .take_i    (take),
        .done_i    (done),
        .rx_word_i (rx_word),
        .busy_i    (busy),
        .go_o      (go),
        .word_o    (tx_word),
        .cfg_o     (cfg),
        .cpol_o    (cpol),
        .rx_en_o   (rx_en),
        .rx_full_o (rx_full),
        .lost_o    (lost),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    spi_host_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .go_i      (go),
        .word_i    (tx_word),
        .cfg_i     (cfg),
        .cpol_i    (cpol),
        .miso_i    (miso_i),
        .take_o    (take),
        .done_o    (done),
        .rx_word_o (rx_word),
        .busy_o    (busy),
        .cs_no     (cs_no),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o)
    );
endmodule

// File: rtl/spi_host_regport_chk.sv
module spi_host_regport_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cs_n,
    input logic       sclk,
    input logic       cpol,
    input logic       busy,
    input logic       lost,
    input logic       rx_full,
    input logic       done,
    input logic       rx_en,
    input logic       rd_en,
    input logic [1:0] rd_addr,
    input logic       take,
    input logic       go,
    input logic       irq,
    input logic [3:0] mask
);
    a_r5_idle_clock_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n |-> (sclk == cpol));

    a_r8_lost_needs_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lost) |-> $past(done && rx_full && rx_en));

    a_r7_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en && rd_addr == 2'd3 && !(done && rx_en)) |=> !rx_full);

    a_r7_select_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n |-> busy);

    a_r3_take_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> go);

    a_r9_no_irq_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask == 4'd0) |-> !irq);
endmodule

bind spi_host_regport spi_host_regport_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n    (cs_no),
    .sclk    (sclk_o),
    .cpol    (cpol),
    .busy    (busy),
    .lost    (lost),
    .rx_full (rx_full),
    .done    (done),
    .rx_en   (rx_en),
    .rd_en   (rd_en_i),
    .rd_addr (rd_addr_i),
    .take    (take),
    .go      (go),
    .irq     (irq_o),
    .mask    (mask)
);

// File: tb/spi_host_regport_tb.sv
module spi_host_regport_tb;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, cs_n, sclk, mosi;
    logic        miso = 1'b0;

    int nchk = 0, nfail = 0;

    spi_host_regport u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq), .cs_no(cs_n), .sclk_o(sclk),
        .mosi_o(mosi), .miso_i(miso)
    );

    always #2 clk = ~clk;

    // device model
    logic        s_cpol = 0, s_cpha = 0, s_lsb = 0;
    int          s_n = 8;
    logic [31:0] s_word = '0, s_cap = '0;
    int          k_out = 0, j_in = 0;
    logic        s_sel = 0, s_prev = 0;

    function automatic int posn(input int k);
        return s_lsb ? k : s_n - 1 - k;
    endfunction

    always @(sclk, cs_n) begin
        if (cs_n) begin
            s_sel = 1'b0;
        end else if (!s_sel) begin
            s_sel = 1'b1; k_out = 0; j_in = 0; s_cap = '0;
            if (!s_cpha) miso = s_word[posn(0)];
        end else if (sclk !== s_prev) begin
            if (sclk !== s_cpol) begin
                if (!s_cpha) begin s_cap[posn(j_in)] = mosi; j_in = (j_in + 1) % s_n; end
                else begin miso = s_word[posn(k_out)]; k_out = (k_out + 1) % s_n; end
            end else begin
                if (!s_cpha) begin k_out = (k_out + 1) % s_n; miso = s_word[posn(k_out)]; end
                else begin s_cap[posn(j_in)] = mosi; j_in = (j_in + 1) % s_n; end
            end
        end
        s_prev = sclk;
    end

    // pin monitors sampled between edges
    int cyc = 0, last_rise = -1, per = 0, cs_rises = 0, cs_falls = 0;
    logic m_sclk = 0, m_cs = 1;
    always @(negedge clk) begin
        cyc++;
        if (cs_n) last_rise = -1;
        else if (!m_sclk && sclk) begin
            if (last_rise >= 0) per = cyc - last_rise;
            last_rise = cyc;
        end
        if (!m_cs && cs_n) cs_rises++;
        if (m_cs && !cs_n) cs_falls++;
        m_sclk = sclk;
        m_cs = cs_n;
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] q);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0; q = rd_data;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic en, mst, txen, rxen, cpol, cpha,
                                            pulse, lsb, input logic [1:0] sz,
                                            input logic [2:0] dv);
        return 32'(en) | (32'(mst) << 1) | (32'(txen) << 2) | (32'(rxen) << 3) |
               (32'(cpol) << 4) | (32'(cpha) << 5) | (32'(pulse) << 6) |
               (32'(lsb) << 7) | (32'(sz) << 10) | (32'(dv) << 20);
    endfunction

    function automatic logic [31:0] low_bits(input logic [31:0] w, input int n);
        return (n >= 32) ? w : (w & ((32'd1 << n) - 1));
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        bit ok = 0;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd2, s);
            if (!s[2] && s[1]) begin ok = 1; break; end
        end
        check("R3 transfer completes", 32'(ok), 32'd1);
    endtask

    task automatic run_word(input logic cpol, cpha, lsb, txen, rxen,
                            input logic [1:0] sz, input logic [2:0] dv,
                            input logic [31:0] tx, sw, input bit fetch);
        logic [31:0] q;
        int n = 8 * (int'(sz) + 1);
        s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_n = n; s_word = sw;
        wr(2'd0, mk_ctrl(1, 1, txen, rxen, cpol, cpha, 0, lsb, sz, dv));
        wr(2'd3, tx);
        wait_idle();
        check("R5 sclk period", 32'(per), 32'd1 << (int'(dv) + 1));
        check("R4/R6 word seen on MOSI", s_cap, txen ? low_bits(tx, n) : 32'd0);
        if (fetch) begin
            rd(2'd3, q);
            check("R4 word returned from MISO", q, low_bits(sw, n));
        end
    endtask

    task automatic main_seq();
        logic [31:0] q, a, b;
        logic [31:0] rnd;
        rnd = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 cs high", 32'(cs_n), 32'd1);
        check("R1 sclk low", 32'(sclk), 32'd0);
        check("R1 irq low", 32'(irq), 32'd0);
        rd(2'd2, q); check("R1 status", q, 32'h2);
        rd(2'd0, q); check("R1 control", q, 32'h0);

        // R2 control field retention
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, q); check("R2 control readback", q, 32'h0070_0CFF);
        wr(2'd0, 32'h0);

        // R9 interrupt masking
        wr(2'd1, 32'h2); check("R9 irq on tx-empty", 32'(irq), 32'd1);
        wr(2'd1, 32'h1); check("R9 irq off rx-empty", 32'(irq), 32'd0);
        run_word(0, 0, 0, 1, 1, 2'd0, 3'd0, 32'hA5, 32'h3C, 0);
        check("R9 irq on rx-full", 32'(irq), 32'd1);
        rd(2'd3, q); check("R7 data read", q, 32'h3C);
        check("R9 irq clears after read", 32'(irq), 32'd0);
        rd(2'd2, q); check("R7 rx-full cleared", q, 32'h2);
        wr(2'd1, 32'h0);

        // random sweep R4 R5
        for (int i = 0; i < 24; i++) begin
            logic [31:0] r = $urandom;
            run_word(r[0], r[1], r[2], 1, 1, r[4:3], 3'(r[6:5] % 3), $urandom, $urandom, 1);
        end

        // R3 held word when disabled
        wr(2'd0, mk_ctrl(0, 1, 1, 1, 0, 0, 0, 0, 2'd1, 3'd1));
        cs_falls = 0;
        s_cpol = 0; s_cpha = 0; s_lsb = 0; s_n = 16; s_word = 32'h1234;
        wr(2'd3, 32'hBEEF);
        repeat (40) @(negedge clk);
        check("R3 no select while disabled", 32'(cs_falls), 32'd0);
        rd(2'd2, q); check("R3 tx-empty cleared, idle", q, 32'h0);
        wr(2'd0, mk_ctrl(1, 1, 1, 1, 0, 0, 0, 0, 2'd1, 3'd1));
        wait_idle();
        check("R3 held word sent", s_cap, 32'hBEEF);
        rd(2'd3, q); check("R3 held word reply", q, 32'h1234);

        // R6 transmit and receive disabled
        run_word(1, 0, 0, 0, 0, 2'd0, 3'd0, 32'hFF, 32'h77, 0);
        rd(2'd2, q); check("R6 rx-full unchanged", q, 32'h2);
        rd(2'd3, q); check("R6 rx buffer unchanged", q, 32'h1234);

        // R8 overrun
        a = 32'h5A; b = 32'hC3;
        run_word(0, 1, 1, 1, 1, 2'd0, 3'd0, 32'h11, a, 0);
        run_word(0, 1, 1, 1, 1, 2'd0, 3'd0, 32'h22, b, 0);
        rd(2'd2, q); check("R8 lost set", q, 32'hB);
        rd(2'd3, q); check("R8 newest word kept", q, b);
        rd(2'd2, q); check("R8 lost sticky after read", q, 32'hA);
        wr(2'd1, 32'h8);
        rd(2'd2, q); check("R8 lost cleared by mask write", q, 32'h2);
        check("R9 irq low with lost cleared", 32'(irq), 32'd0);
        wr(2'd1, 32'h0);

        // R10 back-to-back words, both chip-select modes
        for (int p = 0; p < 2; p++) begin
            s_cpol = 0; s_cpha = 0; s_lsb = 0; s_n = 8; s_word = 32'h0F;
            wr(2'd0, mk_ctrl(1, 1, 1, 0, 0, 0, 1'(p), 0, 2'd0, 3'd0));
            cs_rises = 0;
            wr(2'd3, 32'h81);
            for (int i = 0; i < 50; i++) begin
                rd(2'd2, q);
                if (q[1]) break;
            end
            wr(2'd3, 32'h42);
            wait_idle();
            check(p ? "R10 pulsed select rises" : "R10 held select rises",
                  32'(cs_rises), p ? 32'd2 : 32'd1);
        end
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (LIMIT) @(posedge clk);
                nfail++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", LIMIT, LIMIT);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule